// File: doc/BRIEF.md
# Translation Cache with Hardware Two-Level Walk

This block turns virtual addresses into physical addresses. It keeps a small fully associative set of recent translations. A request that hits one of them is answered without touching memory. A request that misses makes a built-in walker read a top-level table entry and then a leaf table entry over a simple memory read port. The walker installs the leaf entry and then repeats the lookup, so every answer comes from the cached copy. Each answer is one of three kinds: a physical address, a not-present fault, or a protection fault.

Software keeps the cache consistent with the tables in two ways. It can drop the one translation that belongs to a given virtual page number. It can also empty the whole cache in a single cycle, for example when the address space changes. The block accepts one request at a time. It holds off new requests while a walk is running and while an invalidate or a flush command is asserted. When the cache is full, a new translation takes a free slot if one exists. Otherwise it replaces the lowest-numbered slot that was not used most recently.

Top module: `xlat_cache`

## Requirements
- R1: When a request hits a cached translation that is present, and writable if the request is a write, the response carries fault code 0. The physical address is the cached frame number placed above the untouched 12-bit page offset. The response arrives in the cycle after the lookup cycle, with no memory read.
- R2: A miss causes exactly two memory reads. The first read is at {root_pfn, va[31:22], 2'b00}. The second is at {frame of the first word, va[21:12], 2'b00}. The second word is then installed and the lookup is repeated.
- R3: In a table word, the frame number is bits [31:12]. Bit 0 means present and bit 1 means writable.
- R4: If the top-level word is not present, the walk stops after one read and responds with fault code 1 (not present). Nothing is installed, so the same request walks again.
- R5: If the leaf word is not present, the response has fault code 1 and a zero address. The leaf word stays cached, so a repeat of the request faults again with no memory read.
- R6: A write to a present page whose writable bit is clear responds with fault code 2 (protection) and a zero address. A read of the same page succeeds.
- R7: An invalidate command removes only the translation whose virtual page number equals inv_vpn. The next access to that page walks again and sees the current table word. Other cached pages still hit.
- R8: A flush clears every cached translation in one cycle, so the next request to any page walks.
- R9: A fill uses the lowest free slot. If no slot is free, the fill replaces the lowest-numbered slot other than the one that hit most recently.
- R10: req_ready is low while a request is being translated and during any cycle in which inv_valid or flush is high.
- R11: mem_rd_req stays high with a steady mem_rd_addr until mem_rd_ack is seen.
- R12: After reset, no translation is cached, req_ready is high, and neither a response nor a memory read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_pfn | input | 20 | Frame holding the top-level table, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| mem_rd_req | output | 1 | Walker read request |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table word |
| inv_valid | input | 1 | Invalidate one translation |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush | input | 1 | Drop all translations |

## Verification
The main function is tried with several patterns:
- A cold miss and a warm hit on the same page, which separate the walk path from the cached path through read count and latency.
- A write followed by a read to a read-only page, which separates a protection fault from a successful read.
- A leaf word that is not present, which is shown to be cached by a zero-read repeat fault.
- A top-level word that is not present, which is shown to stop after one read and to be re-walked each time.

Invalidate, flush and replacement are each judged by which later requests walk and which do not. The replacement sequence deliberately moves the most-recently-used slot between slot 0 and other slots, so lowest-free, lowest-other-than-recent and the ordinary lowest choice give different outcomes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int IDX1_W  = 10;
    localparam int IDX2_W  = 10;
    localparam int OFF_W   = 12;
    localparam int PFN_W   = 20;
    localparam int PTE_W   = 32;
    localparam int VPN_W   = IDX1_W + IDX2_W;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int PRES_B  = 0;
    localparam int WRIT_B  = 1;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             present;
        logic             writable;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_PAGE = 2'd1,
        XF_PROT = 2'd2
    } xfault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MASTER,
        ST_LEAF
    } walk_st_e;

    function automatic logic [PFN_W-1:0] pte_pfn(input logic [PTE_W-1:0] w);
        return w[PTE_W-1 -: PFN_W];
    endfunction

    function automatic logic pte_present(input logic [PTE_W-1:0] w);
        return w[PRES_B];
    endfunction

    function automatic logic pte_writable(input logic [PTE_W-1:0] w);
        return w[WRIT_B];
    endfunction

    // Table word address: frame of the table, index, word aligned.
    function automatic logic [PA_W-1:0] tbl_addr(input logic [PFN_W-1:0] base,
                                                 input logic [IDX1_W-1:0] idx);
        return {base, idx, 2'b00};
    endfunction

    function automatic xfault_e entry_fault(input tlb_ent_t e, input logic wr);
        if (!e.present)            return XF_PAGE;
        else if (wr && !e.writable) return XF_PROT;
        else                        return XF_NONE;
    endfunction

endpackage

// File: rtl/xlat_tags.sv
module xlat_tags
    import xlat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output tlb_ent_t         hit_ent,
    input  logic             touch,
    input  logic             fill_en,
    input  tlb_ent_t         fill_ent,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);

    tlb_ent_t            ent_q [N_ENT];
    logic [N_ENT-1:0]    live_q;
    logic [SLOT_W-1:0]   mru_q;
    logic [N_ENT-1:0]    match;
    logic [N_ENT-1:0]    inv_match;
    logic [SLOT_W-1:0]   hit_idx;
    logic [SLOT_W-1:0]   free_idx;
    logic [SLOT_W-1:0]   evict_idx;
    logic [SLOT_W-1:0]   fill_idx;
    logic                have_free;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
        assign match[gi]     = live_q[gi] && (ent_q[gi].vpn == look_vpn);
        assign inv_match[gi] = live_q[gi] && (ent_q[gi].vpn == inv_vpn);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_ent = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = SLOT_W'(i);
                hit_ent = ent_q[i];
            end
        end
    end

    always_comb begin
        have_free = ~&live_q;
        free_idx  = '0;
        evict_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!live_q[i])               free_idx  = SLOT_W'(i);
            if (SLOT_W'(i) != mru_q)      evict_idx = SLOT_W'(i);
        end
        fill_idx = have_free ? free_idx : evict_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            mru_q  <= '0;
        end else begin
            if (flush) begin
                live_q <= '0;
            end else begin
                if (inv_en)  live_q           <= live_q & ~inv_match;
                if (fill_en) live_q[fill_idx] <= 1'b1;
            end
            if (touch && hit) mru_q <= hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) ent_q[fill_idx] <= fill_ent;
    end

    // R9
    evict_not_mru_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !have_free) |-> (fill_idx != mru_q));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (live_q == '0));

    // R7
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !fill_en) |=> ((live_q & $past(inv_match)) == '0));

    // R2
    unique_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PFN_W-1:0] root_pfn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output xfault_e          rsp_fault,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             cmd_busy,
    output logic [VPN_W-1:0] look_vpn,
    input  logic             hit,
    input  tlb_ent_t         hit_ent,
    output logic             touch,
    output logic             fill_en,
    output tlb_ent_t         fill_ent
);

    walk_st_e         st_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [PFN_W-1:0] root_q;
    logic [PFN_W-1:0] leaf_base_q;
    logic             rsp_v_q;
    xfault_e          rsp_f_q;
    logic [PA_W-1:0]  rsp_pa_q;
    xfault_e          look_flt;
    logic [IDX1_W-1:0] idx1;
    logic [IDX2_W-1:0] idx2;

    assign idx1      = va_q[VA_W-1 -: IDX1_W];
    assign idx2      = va_q[OFF_W +: IDX2_W];
    assign look_vpn  = va_q[VA_W-1:OFF_W];
    assign look_flt  = entry_fault(hit_ent, wr_q);
    assign req_ready = (st_q == ST_IDLE) && !cmd_busy;
    assign touch     = (st_q == ST_LOOK);

    assign mem_rd_req  = (st_q == ST_MASTER) || (st_q == ST_LEAF);
    assign mem_rd_addr = (st_q == ST_LEAF) ? tbl_addr(leaf_base_q, idx2)
                                           : tbl_addr(root_q, idx1);

    assign fill_en           = (st_q == ST_LEAF) && mem_rd_ack;
    assign fill_ent.vpn      = look_vpn;
    assign fill_ent.pfn      = pte_pfn(mem_rd_data);
    assign fill_ent.present  = pte_present(mem_rd_data);
    assign fill_ent.writable = pte_writable(mem_rd_data);

    assign rsp_valid = rsp_v_q;
    assign rsp_fault = rsp_f_q;
    assign rsp_paddr = rsp_pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            root_q      <= '0;
            leaf_base_q <= '0;
            rsp_v_q     <= 1'b0;
            rsp_f_q     <= XF_NONE;
            rsp_pa_q    <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        va_q   <= req_vaddr;
                        wr_q   <= req_write;
                        root_q <= root_pfn;
                        st_q   <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit) begin
                        rsp_v_q  <= 1'b1;
                        rsp_f_q  <= look_flt;
                        rsp_pa_q <= (look_flt == XF_NONE) ?
                                    {hit_ent.pfn, va_q[OFF_W-1:0]} : '0;
                        st_q     <= ST_IDLE;
                    end else begin
                        st_q     <= ST_MASTER;
                    end
                end
                ST_MASTER: begin
                    if (mem_rd_ack) begin
                        if (!pte_present(mem_rd_data)) begin
                            rsp_v_q  <= 1'b1;
                            rsp_f_q  <= XF_PAGE;
                            rsp_pa_q <= '0;
                            st_q     <= ST_IDLE;
                        end else begin
                            leaf_base_q <= pte_pfn(mem_rd_data);
                            st_q        <= ST_LEAF;
                        end
                    end
                end
                ST_LEAF: begin
                    if (mem_rd_ack) st_q <= ST_LOOK;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R6
    prot_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == XF_PROT) |-> wr_q);

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != XF_NONE) |-> (rsp_paddr == '0));

    // R10
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req || rsp_valid) |-> !$past(req_ready));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PFN_W-1:0] root_pfn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);

    logic [VPN_W-1:0] look_vpn;
    logic             hit;
    tlb_ent_t         hit_ent;
    logic             touch;
    logic             fill_en;
    tlb_ent_t         fill_ent;
    xfault_e          flt;

    assign rsp_fault = flt;

    xlat_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .root_pfn    (root_pfn),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .req_write   (req_write),
        .rsp_valid   (rsp_valid),
        .rsp_paddr   (rsp_paddr),
        .rsp_fault   (flt),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .cmd_busy    (inv_valid | flush),
        .look_vpn    (look_vpn),
        .hit         (hit),
        .hit_ent     (hit_ent),
        .touch       (touch),
        .fill_en     (fill_en),
        .fill_ent    (fill_ent)
    );

    xlat_tags #(.N_ENT(N_ENT)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .look_vpn (look_vpn),
        .hit      (hit),
        .hit_ent  (hit_ent),
        .touch    (touch),
        .fill_en  (fill_en),
        .fill_ent (fill_ent),
        .inv_en   (inv_valid),
        .inv_vpn  (inv_vpn),
        .flush    (flush)
    );

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] root_pfn = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int rd_count = 0;
    int wait_cnt = 0;
    logic [31:0] first_addr = '0;
    logic [31:0] log_a [2];
    logic [31:0] pt_mem [logic [31:0]];

    always #4 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst(rst), .root_pfn(root_pfn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Memory model: answers three falling edges after a request is seen.
    always @(negedge clk) begin
        if (rst) begin
            wait_cnt   = 0;
            mem_rd_ack = 1'b0;
        end else if (mem_rd_ack) begin
            mem_rd_ack = 1'b0;
        end else if (mem_rd_req) begin
            if (wait_cnt == 0) first_addr = mem_rd_addr;
            if (wait_cnt == 2) begin
                chk("R11 read address steady", mem_rd_addr, first_addr);
                mem_rd_data = pt_mem.exists(mem_rd_addr) ? pt_mem[mem_rd_addr] : 32'h0;
                mem_rd_ack  = 1'b1;
                log_a[0]    = log_a[1];
                log_a[1]    = mem_rd_addr;
                rd_count++;
                wait_cnt    = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [31:0] mk_va(input int l1, input int l2, input int off);
        return {l1[9:0], l2[9:0], off[11:0]};
    endfunction

    int leak = 0;

    task automatic xlat(input logic [31:0] va, input logic wr,
                        output logic [31:0] pa, output logic [1:0] flt,
                        output int nrd, output int lat);
        int start;
        start     = rd_count;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 500) begin
            if (req_ready) leak++;
            @(negedge clk);
            lat++;
        end
        pa  = rsp_paddr;
        flt = rsp_fault;
        nrd = rd_count - start;
        @(negedge clk);
    endtask

    task automatic expect_x(input string tag, input logic [31:0] va, input logic wr,
                            input logic [1:0] eflt, input logic [31:0] epa, input int erd);
        logic [31:0] pa; logic [1:0] flt; int nrd; int lat;
        xlat(va, wr, pa, flt, nrd, lat);
        chk({tag, " fault"}, {30'd0, flt}, {30'd0, eflt});
        chk({tag, " paddr"}, pa, epa);
        chk({tag, " reads"}, nrd, erd);
        if (erd == 0) chk({tag, " R1 hit latency"}, lat, 2);
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [1:0]  flt;
        logic [31:0] pa;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{32'h00000123, 1'b0, 2'd0, 32'hAAAA0123, 32'd2},
        '{32'h00000FFF, 1'b1, 2'd0, 32'hAAAA0FFF, 32'd0},
        '{32'h00001010, 1'b1, 2'd2, 32'h00000000, 32'd2},
        '{32'h00001010, 1'b0, 2'd0, 32'hBBBB1010, 32'd0},
        '{32'h00002000, 1'b0, 2'd1, 32'h00000000, 32'd2},
        '{32'h00002000, 1'b0, 2'd1, 32'h00000000, 32'd0},
        '{32'h008050AB, 1'b0, 2'd1, 32'h00000000, 32'd1},
        '{32'h008050AB, 1'b0, 2'd1, 32'h00000000, 32'd1}
    };

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R3: frame in [31:12], present bit 0, writable bit 1
        pt_mem[32'h00010000] = 32'h00020001;
        pt_mem[32'h00010004] = 32'h00021001;
        pt_mem[32'h00020000] = 32'hAAAA0003;
        pt_mem[32'h00020004] = 32'hBBBB1001;
        pt_mem[32'h00020008] = 32'h12345000;
        for (int k = 0; k < 8; k++)
            pt_mem[32'h00021000 + 4 * k] = ((32'h50000 + k) << 12) | 32'h3;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R12 no response after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R12 no read after reset", {31'd0, mem_rd_req}, 32'd0);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++)
            expect_x($sformatf("vec%0d R2 R3 R4 R5 R6", i), VEC[i].va, VEC[i].wr,
                     VEC[i].flt, VEC[i].pa, int'(VEC[i].rd));

        // R7: stale entry persists until invalidated, then new word is used
        pt_mem[32'h00020004] = 32'hBBBB1003;
        expect_x("R7 stale before invalidate", mk_va(0, 1, 16), 1'b1, 2'd2, 32'h0, 0);
        inv_vpn   = 20'h00001;
        inv_valid = 1'b1;
        #1;
        chk("R10 ready low during invalidate", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        inv_valid = 1'b0;
        expect_x("R7 rewalk after invalidate", mk_va(0, 1, 16), 1'b1, 2'd0, 32'hBBBB1010, 2);
        expect_x("R7 neighbour kept", mk_va(0, 0, 5), 1'b0, 2'd0, 32'hAAAA0005, 0);

        // R8 flush
        flush = 1'b1;
        #1;
        chk("R10 ready low during flush", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        flush = 1'b0;
        expect_x("R8 walk after flush", mk_va(0, 0, 7), 1'b0, 2'd0, 32'hAAAA0007, 2);

        // R9 replacement: slot0 = 0/0, slots 1..7 = 1/0..1/6
        for (int k = 0; k < 7; k++)
            expect_x("R9 fill free", mk_va(1, k, 0), 1'b0, 2'd0, (32'h50000 + k) << 12, 2);
        expect_x("R9 touch slot0", mk_va(0, 0, 0), 1'b0, 2'd0, 32'hAAAA0000, 0);
        expect_x("R9 evict slot1", mk_va(1, 7, 0), 1'b0, 2'd0, 32'h50007000, 2);
        expect_x("R9 mru slot0 kept", mk_va(0, 0, 0), 1'b0, 2'd0, 32'hAAAA0000, 0);
        expect_x("R9 evicted page walks", mk_va(1, 0, 0), 1'b0, 2'd0, 32'h50000000, 2);
        expect_x("R9 slot2 hit", mk_va(1, 1, 0), 1'b0, 2'd0, 32'h50001000, 0);
        expect_x("R9 evict slot0", mk_va(1, 7, 0), 1'b0, 2'd0, 32'h50007000, 2);
        chk("R2 master read address", log_a[0], 32'h00010004);
        chk("R2 leaf read address", log_a[1], 32'h0002101C);
        expect_x("R9 slot1 kept", mk_va(1, 0, 0), 1'b0, 2'd0, 32'h50000000, 0);
        expect_x("R9 old slot0 walks", mk_va(0, 0, 0), 1'b0, 2'd0, 32'hAAAA0000, 2);
        chk("R2 master read address", log_a[0], 32'h00010000);
        chk("R2 leaf read address", log_a[1], 32'h00020000);

        chk("R10 ready stayed low while busy", leak, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule